// File: doc/BRIEF.md
# Three-Lane DC-Balanced Deserializer

The block takes three serial data lanes, all sampled by one bit-rate clock, and rebuilds one 21-bit parallel word per frame. A frame lasts nine bit times. On every lane it carries two complementary polarity flags followed by seven payload bits. Before sending, the transmitter complements a lane's payload whenever that helps keep its running disparity near zero, and it records that choice in the flags. The receiver reads the flags and undoes the inversion lane by lane.

Frame alignment comes from a single-cycle frame-start pulse that marks the first flag bit. After the first pulse the block counts frames back to back on its own. Any later pulse realigns it at once. The word is presented with a companion strobe. A configuration input chooses whether the downstream logic captures on the strobe's rising edge or on its falling edge. The data always changes on the other edge and stays stable for the whole frame.

Top module: `dcb_deser`

## Requirements
- R1: While rst_ni is low, data_o is 0 and code_err_o is 0. strobe_o sits at its inactive level, which is 0 when rise_capture_i is 1 and 1 when rise_capture_i is 0.
- R2: Lane k (k = 0, 1, 2) fills data_o[7k+6:7k]. Within a frame each lane sends, in order: flag A, flag B, then payload bit 6 down to payload bit 0.
- R3: A lane with flag A = 0 and flag B = 1 is taken as not inverted, and its payload goes to the output unchanged.
- R4: A lane with flag A = 1 and flag B = 0 is taken as inverted, and its payload is complemented. Each lane is decoded on its own flags.
- R5: If flag A equals flag B on any lane, code_err_o is high for exactly the one cycle in which the new word first appears. The payload of that lane is passed through as received, and the other lanes decode normally.
- R6: The lane bit sampled in the cycle where frame_start_i is high is flag A. A pulse in the middle of a frame throws away the partial frame and restarts the frame and the strobe phase.
- R7: data_o is loaded on the clock edge that samples the last payload bit. It is visible from the following cycle and holds for the next nine cycles.
- R8: With rise_capture_i = 1, strobe_o goes low together with each data update. It stays low for five bit cycles (the update cycle and the next four) and high for the four after that, so its rising edge falls in mid-frame while data_o is stable.
- R9: With rise_capture_i = 0, strobe_o is the complement of its R8 waveform, so data changes on its rising edge and is captured on its falling edge.
- R10: Until the first frame_start_i pulse after reset, lane activity loads nothing: data_o stays 0 and code_err_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock, nine cycles per frame |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | One-cycle pulse that marks flag A of a frame |
| lane_i | input | 3 | Serial bit of each lane, one per cycle |
| rise_capture_i | input | 1 | 1: capture on strobe rising edge; 0: on falling edge |
| data_o | output | 21 | Decoded parallel word |
| strobe_o | output | 1 | Output strobe, one period per frame |
| code_err_o | output | 1 | One-cycle pulse when a lane's flags are equal |

## Verification
A wrong bit-position count shows up at once as a frame that completes a cycle early or late. The payload then comes out shifted by one bit, and a flag can leak into bit 6. A swapped or misread flag pair inverts one 7-bit slice of data_o exactly when that word appears. A stuck error state shows as a code_err_o pulse that lasts longer than one cycle. A drifting strobe phase shows within one frame as a change of data_o that lines up with the active edge. Every frame's output is compared in its first visible cycle, and both the held value and the strobe level are compared in every cycle in between.

// File: rtl/dcb_deser_pkg.sv
package dcb_deser_pkg;
  localparam int unsigned LANES      = 3;
  localparam int unsigned PAY_W      = 7;
  localparam int unsigned FLAG_W     = 2;
  localparam int unsigned FRAME_LEN  = PAY_W + FLAG_W;
  localparam int unsigned WORD_W     = LANES * PAY_W;
  localparam int unsigned POS_W      = $clog2(FRAME_LEN);
  localparam int unsigned STROBE_POS = 4;

  typedef logic [POS_W-1:0] pos_t;

  // flag pair as received: {flag_a, flag_b}
  typedef enum logic [1:0] {
    FLAGS_PLAIN = 2'b01,
    FLAGS_INV   = 2'b10,
    FLAGS_BAD0  = 2'b00,
    FLAGS_BAD1  = 2'b11
  } flags_e;
endpackage

// File: rtl/dcb_frame_timer.sv
module dcb_frame_timer
  import dcb_deser_pkg::*;
#(
  parameter int unsigned FRM_LEN = FRAME_LEN,
  parameter int unsigned STB_POS = STROBE_POS,
  localparam int unsigned PW     = $clog2(FRM_LEN)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_start_i,
  output logic shift_en_o,
  output logic last_o,
  output logic strobe_q_o
);
  logic [PW-1:0] pos_q;
  logic [PW-1:0] cur_pos;
  logic          aligned_q;
  logic          active;
  logic          strobe_q;

  assign cur_pos    = frame_start_i ? '0 : pos_q;
  assign active     = frame_start_i | aligned_q;
  assign last_o     = active && (cur_pos == PW'(FRM_LEN - 1));
  assign shift_en_o = active;
  assign strobe_q_o = strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q     <= '0;
      aligned_q <= 1'b0;
    end else if (active) begin
      aligned_q <= 1'b1;
      pos_q     <= last_o ? '0 : PW'(cur_pos + 1'b1);
    end
  end

  // inactive level at update, active level from mid-frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    strobe_q <= 1'b0;
    else if (last_o || frame_start_i)               strobe_q <= 1'b0;
    else if (active && cur_pos == PW'(STB_POS))     strobe_q <= 1'b1;
  end
endmodule

// File: rtl/dcb_lane.sv
module dcb_lane
  import dcb_deser_pkg::*;
#(
  parameter int unsigned PW     = PAY_W,
  parameter int unsigned FW     = FLAG_W,
  localparam int unsigned FLEN  = PW + FW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_en_i,
  input  logic          bit_i,
  output logic [PW-1:0] payload_o,
  output logic          err_o
);
  logic [FLEN-2:0] shift_q;
  logic [FLEN-1:0] full;
  flags_e          flags;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         shift_q <= '0;
    else if (shift_en_i) shift_q <= {shift_q[FLEN-3:0], bit_i};
  end

  // first received bit ends up at the top
  assign full  = {shift_q, bit_i};
  assign flags = flags_e'(full[FLEN-1 -: 2]);

  always_comb begin
    err_o     = 1'b0;
    payload_o = full[PW-1:0];
    unique case (flags)
      FLAGS_INV:   payload_o = ~full[PW-1:0];
      FLAGS_PLAIN: payload_o = full[PW-1:0];
      default:     err_o     = 1'b1;
    endcase
  end
endmodule

// File: rtl/dcb_deser.sv
module dcb_deser
  import dcb_deser_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic [LANES-1:0]  lane_i,
  input  logic              rise_capture_i,
  output logic [WORD_W-1:0] data_o,
  output logic              strobe_o,
  output logic              code_err_o
);
  logic              shift_en;
  logic              last;
  logic              strobe_q;
  logic [WORD_W-1:0] dec_word;
  logic [LANES-1:0]  lane_err;
  logic [WORD_W-1:0] data_q;
  logic              err_q;

  dcb_frame_timer #(
    .FRM_LEN (FRAME_LEN),
    .STB_POS (STROBE_POS)
  ) u_timer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start_i),
    .shift_en_o    (shift_en),
    .last_o        (last),
    .strobe_q_o    (strobe_q)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    dcb_lane #(
      .PW (PAY_W),
      .FW (FLAG_W)
    ) u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .shift_en_i (shift_en),
      .bit_i      (lane_i[l]),
      .payload_o  (dec_word[l*PAY_W +: PAY_W]),
      .err_o      (lane_err[l])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= last && (|lane_err);
      if (last) data_q <= dec_word;
    end
  end

  assign data_o     = data_q;
  assign code_err_o = err_q;
  assign strobe_o   = rise_capture_i ? strobe_q : ~strobe_q;
endmodule

// File: rtl/dcb_deser_chk.sv
module dcb_deser_chk
  import dcb_deser_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rise_capture_i,
  input logic [WORD_W-1:0] data_o,
  input logic              strobe_o,
  input logic              code_err_o
);
  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (data_o == '0) && !code_err_o);

  a_r5_err_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_err_o |=> !code_err_o);

  a_r5_err_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_err_o |-> (strobe_o == !rise_capture_i));

  a_r7_change_on_inactive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_o) |-> (strobe_o == !rise_capture_i));

  a_r8_active_rise_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_capture_i && $rose(strobe_o)) |-> $stable(data_o));

  a_r9_active_fall_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_capture_i && $fell(strobe_o)) |-> $stable(data_o));
endmodule

bind dcb_deser dcb_deser_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .rise_capture_i (rise_capture_i),
  .data_o         (data_o),
  .strobe_o       (strobe_o),
  .code_err_o     (code_err_o)
);

// File: tb/dcb_deser_bench.sv
module dcb_deser_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        frame_start_i = 1'b0;
  logic [2:0]  lane_i = '0;
  logic        rise_capture_i = 1'b1;
  logic [20:0] data_o;
  logic        strobe_o;
  logic        code_err_o;

  int unsigned n_run = 0;
  int unsigned n_fail = 0;
  logic [20:0] exp_word = '0;
  bit          done = 0;

  always #2 clk_i = ~clk_i;

  dcb_deser u_dcb_deser (
    .clk_i, .rst_ni, .frame_start_i, .lane_i, .rise_capture_i,
    .data_o, .strobe_o, .code_err_o
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // transmitted bit b (0..8) of lane l
  function automatic logic tx_bit(logic [20:0] w, logic [2:0] inv, logic [2:0] bad,
                                  logic [2:0] badv, int l, int b);
    logic [6:0] p;
    p = w[7*l +: 7] ^ {7{inv[l]}};
    if (b == 0) return bad[l] ? badv[l] : inv[l];
    if (b == 1) return bad[l] ? badv[l] : ~inv[l];
    return p[8-b];
  endfunction

  function automatic logic [20:0] rx_word(logic [20:0] w, logic [2:0] inv, logic [2:0] bad);
    logic [20:0] r;
    r = w;
    for (int l = 0; l < 3; l++)
      if (bad[l]) r[7*l +: 7] = w[7*l +: 7] ^ {7{inv[l]}};
    return r;
  endfunction

  function automatic logic exp_strobe(int b);
    logic q;
    q = (b >= 4) && (b < 8);
    return rise_capture_i ? q : ~q;
  endfunction

  // called at a negedge; ends at a negedge
  task automatic send_frame(string req, logic [20:0] w, logic [2:0] inv,
                            logic [2:0] bad, logic [2:0] badv, bit fs);
    for (int b = 0; b < 9; b++) begin
      for (int l = 0; l < 3; l++) lane_i[l] = tx_bit(w, inv, bad, badv, l, b);
      frame_start_i = fs && (b == 0);
      @(negedge clk_i);
      if (b < 8) begin
        check({req, " R7 hold"}, 32'(data_o), 32'(exp_word));
        check({req, " R5 err low"}, 32'(code_err_o), 0);
      end
      check({req, " R8/R9 strobe"}, 32'(strobe_o), 32'(exp_strobe(b)));
    end
    frame_start_i = 1'b0;
    exp_word = rx_word(w, inv, bad);
    check({req, " data"}, 32'(data_o), 32'(exp_word));
    check({req, " R5 err"}, 32'(code_err_o), 32'(|bad));
  endtask

  task automatic send_junk(int n);
    for (int i = 0; i < n; i++) begin
      lane_i = 3'($urandom);
      @(negedge clk_i);
      check("R6/R10 no update", 32'(data_o), 32'(exp_word));
      check("R10 no err", 32'(code_err_o), 0);
    end
  endtask

  task automatic do_reset(bit rise);
    rst_ni = 1'b0;
    rise_capture_i = rise;
    frame_start_i = 1'b0;
    exp_word = '0;
    repeat (2) @(negedge clk_i);
    check("R1 data", 32'(data_o), 0);
    check("R1 err", 32'(code_err_o), 0);
    check("R1 strobe", 32'(strobe_o), 32'(!rise));
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_d00d));
    #1;
    do_reset(1'b1);

    // R10: no alignment yet
    send_junk(20);

    // R2/R3: plain lanes, distinct patterns per lane, bit order
    send_frame("R2 R3 plain", 21'h1F_0301, 3'b000, 3'b000, 3'b000, 1);
    send_frame("R2 single bits", 21'b1000000_0000001_1000000, 3'b000, 3'b000, 3'b000, 0);
    // R4: inversion per lane
    send_frame("R4 inv all", 21'h0A_5A5A, 3'b111, 3'b000, 3'b000, 0);
    send_frame("R4 inv lane1", 21'h15_2AD3, 3'b010, 3'b000, 3'b000, 0);
    // R5: equal flags on one lane, both polarities
    send_frame("R5 bad lane0 11", 21'h12_3456, 3'b001, 3'b001, 3'b001, 0);
    send_frame("R5 bad lane2 00", 21'h1A_BCDE, 3'b100, 3'b100, 3'b000, 0);
    send_frame("R5 after err", 21'h00_0000, 3'b000, 3'b000, 3'b000, 0);
    // R6: realign mid-frame
    send_junk(3);
    send_frame("R6 realign", 21'h07_F00F, 3'b101, 3'b000, 3'b000, 1);
    send_junk(5);
    send_frame("R6 realign2", 21'h1F_FFFF, 3'b000, 3'b000, 3'b000, 1);

    for (int i = 0; i < 40; i++)
      send_frame("random rise", 21'($urandom), 3'($urandom),
                 ($urandom % 6 == 0) ? 3'($urandom) : 3'b000, 3'($urandom), ($urandom % 4 == 0));

    // R9: falling-edge capture mode
    do_reset(1'b0);
    send_junk(7);
    send_frame("R9 first", 21'h15_5555, 3'b010, 3'b000, 3'b000, 1);
    for (int i = 0; i < 40; i++)
      send_frame("R9 random", 21'($urandom), 3'($urandom),
                 ($urandom % 6 == 0) ? 3'($urandom) : 3'b000, 3'($urandom), ($urandom % 4 == 0));

    finish_run();
  end
endmodule